// File: doc/BRIEF.md
# Configuration-Switch Serial Command Slave

This block is the command layer of a two-wire serial slave that replaces jumpers or DIP switches with four small stored configuration words. A bit and byte layer in front of it has already found START and STOP conditions and assembled bytes. This block receives those events as single-cycle strobes. It answers each received byte with an ACK or NACK decision and supplies the next byte when the bus master reads.

A write transfer carries an address byte, then a command byte, then data bytes. Only certain command codes are accepted. Command 00h to 03h selects one of the four stored words as a starting point. Command FFh selects the raw switch-input pins for read-back. Commands 10h to 14h are output-source override codes that a downstream selector uses.

Data bytes are held in a staging buffer and are written to the stored words in one commit, and only at STOP. A write-protect input can block this commit. After each commit the device ignores its own address for a parameterised number of cycles. This models the time the storage needs to be programmed.

Top module: `cfgsw_i2c_ctrl`

## Requirements
- R1: The device ACKs an address byte only when bits 7:3 equal ADDR_PREFIX and bits 2:1 equal `dev_sel`; other address bytes are NACKed. Bit 0 set to 1 opens a read and set to 0 opens a write. Every `rx_strobe` gives an `ack_valid` pulse one cycle later.
- R2: The byte after a write address is a command byte. It is ACKed and stored when it is 00h–03h, FFh, or 10h–14h. Any other value is NACKed and ignored.
- R3: Data bytes after a register command (00h–03h) are written into the stored words only on the following STOP, using the low 6 bits of each byte. Stored word n appears at `cfg_regs[6n+5:6n]`. Each commit gives one `commit_pulse`.
- R4: The word pointer starts at the command value and steps by one after each data byte written or read, wrapping from word 3 to word 0.
- R5: Within one transfer, a data byte that would revisit a word already written in that transfer (the fifth byte) is NACKed. That transfer then commits nothing.
- R6: While `wr_lock` is 1, the address and command bytes are still ACKed, every data byte is NACKed, and no stored word changes.
- R7: A data byte that follows an override command (10h–14h) is NACKed. `cmd_out` holds the last accepted command.
- R8: On a read, `tx_valid` follows `tx_req` by one cycle. The returned byte depends on the last command: for 00h–03h it is {2'b00, word at pointer}; for FFh it is {2'b00, `sw_in`}; for any other command it is 00h.
- R9: For LOCK_CYCLES cycles after a commit, the device NACKs its own address.
- R10: A START that arrives before a STOP, a repeated START, or a NACK during a write discards all staged data.
- R11: After reset, all stored words are zero, `cmd_out` is F0h (no override), and no ACK or transmit strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dev_sel | input | 2 | Pin-selected low address bits |
| wr_lock | input | 1 | Write protect, 1 blocks commits |
| sw_in | input | 6 | Raw switch-input pins |
| bus_start | input | 1 | START or repeated START seen |
| bus_stop | input | 1 | STOP seen |
| rx_strobe | input | 1 | A received byte is valid |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Master requests a byte |
| ack_valid | output | 1 | ACK decision valid |
| ack_out | output | 1 | 1 = ACK, 0 = NACK |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Byte to transmit |
| cfg_regs | output | 24 | Four stored 6-bit words |
| cmd_out | output | 8 | Last accepted command |
| commit_pulse | output | 1 | Stored words are written |

## Verification
The bench builds the block with LOCK_CYCLES set to 40 instead of the default, which corresponds to several milliseconds. This short lockout lets the bench see both the address NACK just after a commit and the address ACK once the window has expired, all inside a short run. The bench keeps the default address prefix and register count and ties `dev_sel` to 2'b10. With these settings the pointer wrap, the fifth-byte overflow and the mismatched-pin address can all be checked against fixed byte values.

// File: rtl/cfgsw_pkg.sv
package cfgsw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } cfgsw_state_e;

    localparam logic [7:0] CMD_NO_OVERRIDE = 8'hF0;
    localparam logic [7:0] CMD_PIN_READ    = 8'hFF;
    localparam logic [7:0] CMD_MUX_BASE    = 8'h10;
endpackage

// File: rtl/cfgsw_addr_match.sv
module cfgsw_addr_match #(
    parameter logic [4:0] ADDR_PREFIX = 5'b10101
) (
    input  logic [7:0] addr_byte,
    input  logic [1:0] dev_sel,
    input  logic       locked,
    output logic       hit,
    output logic       is_read
);
    always_comb begin
        hit     = (addr_byte[7:3] == ADDR_PREFIX) && (addr_byte[2:1] == dev_sel) && !locked;
        is_read = addr_byte[0];
    end
endmodule

// File: rtl/cfgsw_lockout.sv
module cfgsw_lockout #(
    parameter int LOCK_CYCLES = 720000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic busy
);
    localparam int LCW = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES + 1);

    logic [LCW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (arm) begin
            cnt_d = LCW'(LOCK_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    generate
        if (LOCK_CYCLES > 0) begin : g_chk
            // R9
            lock_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
                arm |=> busy);
        end
    endgenerate
endmodule

// File: rtl/cfgsw_regfile.sv
module cfgsw_regfile #(
    parameter int NREG = 4,
    parameter int DW   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [NREG-1:0]    wmask,
    input  logic [NREG*DW-1:0] wdata,
    output logic [NREG*DW-1:0] regs
);
    logic [NREG*DW-1:0] regs_d, regs_q;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_word
            always_comb begin
                regs_d[i*DW +: DW] = regs_q[i*DW +: DW];
                if (commit && wmask[i]) regs_d[i*DW +: DW] = wdata[i*DW +: DW];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(regs_q));
endmodule

// File: rtl/cfgsw_i2c_ctrl.sv
module cfgsw_i2c_ctrl
    import cfgsw_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b10101,
    parameter int         NREG        = 4,
    parameter int         DW          = 6,
    parameter int         LOCK_CYCLES = 720000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         dev_sel,
    input  logic               wr_lock,
    input  logic [DW-1:0]      sw_in,
    input  logic               bus_start,
    input  logic               bus_stop,
    input  logic               rx_strobe,
    input  logic [7:0]         rx_data,
    input  logic               tx_req,
    output logic               ack_valid,
    output logic               ack_out,
    output logic               tx_valid,
    output logic [7:0]         tx_data,
    output logic [NREG*DW-1:0] cfg_regs,
    output logic [7:0]         cmd_out,
    output logic               commit_pulse
);
    localparam int         PW       = (NREG < 2) ? 1 : $clog2(NREG);
    localparam logic [7:0] MUX_LAST = CMD_MUX_BASE + 8'(NREG);

    typedef struct packed {
        cfgsw_state_e       st;
        logic [7:0]         cmd;
        logic [PW-1:0]      ptr;
        logic [NREG-1:0]    mask;
        logic [NREG*DW-1:0] wbuf;
        logic               ack_v;
        logic               ack;
        logic               tx_v;
        logic [7:0]         tx;
    } ctl_t;

    ctl_t d, q;
    logic addr_hit, addr_rd, lock_busy, commit, reg_cmd, cmd_ok;

    cfgsw_addr_match #(.ADDR_PREFIX(ADDR_PREFIX)) u_match (
        .addr_byte (rx_data),
        .dev_sel   (dev_sel),
        .locked    (lock_busy),
        .hit       (addr_hit),
        .is_read   (addr_rd)
    );

    cfgsw_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (commit),
        .busy  (lock_busy)
    );

    cfgsw_regfile #(.NREG(NREG), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .wmask  (q.mask),
        .wdata  (q.wbuf),
        .regs   (cfg_regs)
    );

    always_comb begin
        reg_cmd = (32'(q.cmd) < NREG);
        cmd_ok  = (32'(rx_data) < NREG) || (rx_data == CMD_PIN_READ) ||
                  ((rx_data >= CMD_MUX_BASE) && (rx_data <= MUX_LAST));
    end

    always_comb begin
        d       = q;
        d.ack_v = 1'b0;
        d.tx_v  = 1'b0;
        commit  = 1'b0;
        if (bus_start) begin
            d.st   = ST_ADDR;
            d.mask = '0;
        end else if (bus_stop) begin
            commit = (q.st == ST_WDATA) && (q.mask != '0) && !wr_lock;
            d.mask = '0;
            d.st   = ST_IDLE;
        end else if (rx_strobe) begin
            d.ack_v = 1'b1;
            d.ack   = 1'b0;
            case (q.st)
                ST_ADDR: begin
                    if (addr_hit) begin
                        d.ack = 1'b1;
                        d.st  = addr_rd ? ST_RDATA : ST_CMD;
                    end else begin
                        d.st = ST_SKIP;
                    end
                end
                ST_CMD: begin
                    if (cmd_ok) begin
                        d.ack = 1'b1;
                        d.cmd = rx_data;
                        if (32'(rx_data) < NREG) d.ptr = rx_data[PW-1:0];
                        d.st = ST_WDATA;
                    end else begin
                        d.st = ST_SKIP;
                    end
                end
                ST_WDATA: begin
                    if (reg_cmd && !wr_lock && !q.mask[q.ptr]) begin
                        d.ack                  = 1'b1;
                        d.mask[q.ptr]          = 1'b1;
                        d.wbuf[q.ptr*DW +: DW] = rx_data[DW-1:0];
                        d.ptr                  = q.ptr + 1'b1;
                    end else begin
                        d.mask = '0;
                        d.st   = ST_SKIP;
                    end
                end
                default: ;
            endcase
        end
        if (tx_req) begin
            d.tx_v = 1'b1;
            d.tx   = '0;
            if (q.st == ST_RDATA) begin
                if (reg_cmd) begin
                    d.tx[DW-1:0] = cfg_regs[q.ptr*DW +: DW];
                    d.ptr        = q.ptr + 1'b1;
                end else if (q.cmd == CMD_PIN_READ) begin
                    d.tx[DW-1:0] = sw_in;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cmd   <= CMD_NO_OVERRIDE;
        end else begin
            q <= d;
        end
    end

    assign ack_valid    = q.ack_v;
    assign ack_out      = q.ack;
    assign tx_valid     = q.tx_v;
    assign tx_data      = q.tx;
    assign cmd_out      = q.cmd;
    assign commit_pulse = commit;

    // R1
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !bus_start && !bus_stop) |=> ack_valid);

    // R6
    wp_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WDATA && rx_strobe && wr_lock && !bus_start && !bus_stop) |=> !ack_out);

    // R9
    lock_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && rx_strobe && lock_busy && !bus_start && !bus_stop)
        |=> (ack_valid && !ack_out));

    // R8
    tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);
endmodule

// File: tb/cfgsw_i2c_ctrl_bench.sv
`timescale 1ns/1ps
module cfgsw_i2c_ctrl_bench;
    localparam int K_S = 0, K_P = 1, K_W = 2, K_R = 3, K_D = 4;
    localparam int NV = 67;
    // {kind[2:0], data[7:0], expected[7:0], requirement[3:0]}
    localparam logic [22:0] VEC [NV] = '{
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},  // R1 write address
        {3'd2, 8'h01, 8'h01, 4'd2},  // R2 register command
        {3'd2, 8'h11, 8'h01, 4'd3},  // R3
        {3'd2, 8'h22, 8'h01, 4'd3},
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd4, 8'd60, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'h01, 8'h01, 4'd2},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAD, 8'h01, 4'd1},  // R1 read address
        {3'd3, 8'h00, 8'h11, 4'd8},  // R8
        {3'd3, 8'h00, 8'h22, 4'd4},  // R4
        {3'd3, 8'h00, 8'h00, 4'd4},
        {3'd3, 8'h00, 8'h00, 4'd4},  // R4 wrap to word 0
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'hFF, 8'h01, 4'd2},  // R2 pin read command
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAD, 8'h01, 4'd1},
        {3'd3, 8'h00, 8'h2A, 4'd8},  // R8 pins
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'h12, 8'h01, 4'd2},  // R2 override command
        {3'd2, 8'h05, 8'h00, 4'd7},  // R7 data NACK
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAD, 8'h01, 4'd1},
        {3'd3, 8'h00, 8'h00, 4'd8},  // R8 other command reads zero
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'h20, 8'h00, 4'd2},  // R2 reserved command
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hA8, 8'h00, 4'd1},  // R1 wrong pin bits
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'h03, 8'h01, 4'd2},
        {3'd2, 8'h3F, 8'h01, 4'd4},  // R4 word 3
        {3'd2, 8'h01, 8'h01, 4'd4},  // R4 wraps to word 0
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd4, 8'd60, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'h00, 8'h01, 4'd2},
        {3'd2, 8'h07, 8'h01, 4'd5},  // R5
        {3'd2, 8'h08, 8'h01, 4'd5},
        {3'd2, 8'h09, 8'h01, 4'd5},
        {3'd2, 8'h0A, 8'h01, 4'd5},
        {3'd2, 8'h0B, 8'h00, 4'd5},  // R5 fifth byte NACK
        {3'd1, 8'h00, 8'h00, 4'd0},
        {3'd4, 8'd60, 8'h00, 4'd0},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAC, 8'h01, 4'd1},
        {3'd2, 8'h00, 8'h01, 4'd2},
        {3'd0, 8'h00, 8'h00, 4'd0},
        {3'd2, 8'hAD, 8'h01, 4'd1},
        {3'd3, 8'h00, 8'h01, 4'd5},  // R5 words unchanged
        {3'd3, 8'h00, 8'h11, 4'd5},
        {3'd3, 8'h00, 8'h22, 4'd5},
        {3'd3, 8'h00, 8'h3F, 4'd5},
        {3'd1, 8'h00, 8'h00, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  dev_sel = 2'b10;
    logic        wr_lock = 1'b0;
    logic [5:0]  sw_in = 6'h2A;
    logic        bus_start = 1'b0, bus_stop = 1'b0, rx_strobe = 1'b0, tx_req = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        ack_valid, ack_out, tx_valid, commit_pulse;
    logic [7:0]  tx_data, cmd_out;
    logic [23:0] cfg_regs;
    logic [22:0] v;
    int checks = 0, failures = 0, ncommit = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfgsw_i2c_ctrl #(.LOCK_CYCLES(40)) u_cfgsw_i2c_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .wr_lock(wr_lock), .sw_in(sw_in),
        .bus_start(bus_start), .bus_stop(bus_stop), .rx_strobe(rx_strobe), .rx_data(rx_data),
        .tx_req(tx_req), .ack_valid(ack_valid), .ack_out(ack_out), .tx_valid(tx_valid),
        .tx_data(tx_data), .cfg_regs(cfg_regs), .cmd_out(cmd_out), .commit_pulse(commit_pulse)
    );

    always @(posedge clk) if (rst_n && commit_pulse) ncommit++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic e, input string req);
        @(negedge clk); rx_data = b; rx_strobe = 1'b1;
        @(negedge clk); rx_strobe = 1'b0;
        check(ack_valid === 1'b1 && ack_out === e, req, {30'd0, ack_valid, ack_out}, {30'd0, 1'b1, e});
    endtask

    task automatic fetch(input logic [7:0] e, input string req);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        check(tx_valid === 1'b1 && tx_data === e, req, {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, e});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(cfg_regs === 24'h0, "R11", 32'(cfg_regs), 32'h0);
        check(cmd_out === 8'hF0, "R11", 32'(cmd_out), 32'hF0);
        check(ack_valid === 1'b0 && tx_valid === 1'b0, "R11", {ack_valid, tx_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            case (int'(v[22:20]))
                K_S: pulse_start();
                K_P: pulse_stop();
                K_W: send(v[19:12], v[4], $sformatf("R%0d", v[3:0]));
                K_R: fetch(v[11:4], $sformatf("R%0d", v[3:0]));
                K_D: repeat (int'(v[19:12])) @(negedge clk);
                default: ;
            endcase
        end
        // R3 R4 word layout after the table
        check(cfg_regs === {6'h3F, 6'h22, 6'h11, 6'h01}, "R3", 32'(cfg_regs),
              32'({6'h3F, 6'h22, 6'h11, 6'h01}));

        // R7 override command kept in cmd_out
        pulse_start(); send(8'hAC, 1'b1, "R1"); send(8'h13, 1'b1, "R7"); pulse_stop();
        check(cmd_out === 8'h13, "R7", 32'(cmd_out), 32'h13);

        // R6 write protect
        wr_lock = 1'b1;
        pulse_start(); send(8'hAC, 1'b1, "R6"); send(8'h02, 1'b1, "R6"); send(8'h15, 1'b0, "R6");
        pulse_stop();
        repeat (2) @(negedge clk);
        check(cfg_regs[17:12] === 6'h22, "R6", 32'(cfg_regs[17:12]), 32'h22);
        wr_lock = 1'b0;

        // R9 lockout after a commit
        pulse_start(); send(8'hAC, 1'b1, "R9"); send(8'h02, 1'b1, "R9"); send(8'h05, 1'b1, "R3");
        pulse_stop();
        check(cfg_regs[17:12] === 6'h05, "R3", 32'(cfg_regs[17:12]), 32'h05);
        pulse_start(); send(8'hAC, 1'b0, "R9"); pulse_stop();
        repeat (10) @(negedge clk);
        pulse_start(); send(8'hAC, 1'b0, "R9"); pulse_stop();
        repeat (50) @(negedge clk);
        pulse_start(); send(8'hAC, 1'b1, "R9"); pulse_stop();

        // R10 repeated START discards staged data
        pulse_start(); send(8'hAC, 1'b1, "R10"); send(8'h02, 1'b1, "R10"); send(8'h2E, 1'b1, "R10");
        pulse_start(); pulse_stop();
        repeat (3) @(negedge clk);
        check(cfg_regs[17:12] === 6'h05, "R10", 32'(cfg_regs[17:12]), 32'h05);

        // R10 NACK discards staged data
        pulse_start(); send(8'hAC, 1'b1, "R10"); send(8'h00, 1'b1, "R10"); send(8'h1C, 1'b1, "R10");
        wr_lock = 1'b1; send(8'h1D, 1'b0, "R10"); wr_lock = 1'b0;
        pulse_stop();
        repeat (3) @(negedge clk);
        check(cfg_regs[5:0] === 6'h01, "R10", 32'(cfg_regs[5:0]), 32'h01);

        // R3 one commit per committed transfer
        check(ncommit == 3, "R3", 32'(ncommit), 32'd3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule